// File: doc/BRIEF.md
# Operator Panel Memory Controller

This block sits between a bank of pushbuttons and a small CPU system. It lets an operator start and halt the CPU, hold the CPU in reset, and examine or deposit memory while the CPU is stopped. The button inputs arrive as debounced levels. The block turns each press into exactly one action, taken on the button's rising edge.

While the CPU runs, the address and data LEDs follow the CPU's live buses. While the CPU is halted, the LEDs show the panel's own 16-bit address and the last byte read or written. An address-entry mode loads that address from a bank of switches. A deposit mode makes the increment button write the data switches to memory and then advance the address. With neither mode on, the increment button advances the address and reads the new location. Each memory access is one clock cycle long, with a registered strobe.

Top module: `fpanel_top`

## Requirements
- R1: After reset, `cpu_run`, `led_run`, `led_addr_mode`, `led_wr_mode`, `mem_we`, `mem_re` and `cpu_reset` are 0, and with the CPU halted `led_addr` is 0x0000.
- R2: Each rising edge of `btn_run` toggles `cpu_run` on the next clock edge, and `led_run` equals `cpu_run`.
- R3: `cpu_reset` follows the level of `btn_cpu_rst`, delayed by one clock.
- R4: While `cpu_run` is 1, `led_addr` shows `cpu_addr` and `led_data` shows `cpu_data`. No panel memory access is made while running, and the panel address is unchanged when the CPU is halted again.
- R5: A rising edge of `btn_addr_mode` toggles address-entry mode, shown on `led_addr_mode`. While in that mode and halted, any change of `sw_addr` loads the new value into the panel address on the next clock edge.
- R6: A rising edge of `btn_clear` sets the panel address to 0x0000, but only in address-entry mode. Outside that mode it has no effect.
- R7: A rising edge of `btn_incr` in address-entry mode causes no memory access and leaves the panel address unchanged.
- R8: A rising edge of `btn_wr_mode` toggles deposit mode, shown on `led_wr_mode`. In deposit mode, an increment press writes `sw_data` to the current panel address and then advances the address by one. After the write, `led_data` shows the written byte.
- R9: Outside both modes, an increment press advances the address by one and reads the new location. The byte on `mem_rdata` during the read strobe cycle is shown on `led_data` from the following cycle.
- R10: The panel address wraps from 0xFFFF to 0x0000, for both reads and writes.
- R11: Holding `btn_incr` high for many cycles produces exactly one memory access.
- R12: `mem_we` and `mem_re` are never high together, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| btn_run | input | 1 | Run/halt button level |
| btn_cpu_rst | input | 1 | CPU reset button level |
| btn_clear | input | 1 | Clear-address button level |
| btn_incr | input | 1 | Increment/step button level |
| btn_addr_mode | input | 1 | Address-entry mode toggle button |
| btn_wr_mode | input | 1 | Deposit mode toggle button |
| sw_addr | input | 16 | Address entry switches |
| sw_data | input | 8 | Data entry switches |
| cpu_addr | input | 16 | Live CPU address bus |
| cpu_data | input | 8 | Live CPU data bus |
| mem_rdata | input | 8 | Memory read data, valid during `mem_re` |
| cpu_run | output | 1 | 1 = CPU runs, 0 = halted |
| cpu_reset | output | 1 | Reset to the CPU |
| mem_addr | output | 16 | Panel access address |
| mem_wdata | output | 8 | Panel write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| led_addr | output | 16 | Address display |
| led_data | output | 8 | Data display |
| led_run | output | 1 | Run indicator |
| led_addr_mode | output | 1 | Address-entry mode indicator |
| led_wr_mode | output | 1 | Deposit mode indicator |

## Verification
The bench holds the increment button down for several cycles. A design that acted on levels instead of edges would issue a burst of accesses there, and the scoreboard reports the extra transactions. It walks the address across 0xFFFF for both a read and a write, which catches an address register that saturates or grows a seventeenth bit. It presses increment and clear in the modes where they must do nothing, and it presses increment while the CPU runs, which exposes a missing mode or halt gate as a stray strobe or a moved address. Each read also checks the order of operations: a design that read before advancing would show the old location's byte.

// File: rtl/fpanel_pkg.sv
package fpanel_pkg;
  // Button bit positions within the bundled button vector
  localparam int B_RUN   = 0;
  localparam int B_CRST  = 1;
  localparam int B_CLR   = 2;
  localparam int B_INC   = 3;
  localparam int B_AMODE = 4;
  localparam int B_WMODE = 5;
  localparam int NUM_BTN = 6;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/fpanel_edge.sv
module fpanel_edge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] lvl_q_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end

  assign lvl_q_o = prev_q;
endmodule

// File: rtl/fpanel_mode.sv
module fpanel_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_run,
  input  logic ev_amode,
  input  logic ev_wmode,
  output logic run_o,
  output logic amode_o,
  output logic wmode_o
);
  logic run_q, amode_q, wmode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      amode_q <= 1'b0;
      wmode_q <= 1'b0;
    end else begin
      if (ev_run)   run_q   <= ~run_q;
      if (ev_amode) amode_q <= ~amode_q;
      if (ev_wmode) wmode_q <= ~wmode_q;
    end
  end

  assign run_o   = run_q;
  assign amode_o = amode_q;
  assign wmode_o = wmode_q;
endmodule

// File: rtl/fpanel_seq.sv
module fpanel_seq
  import fpanel_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_ok,
  input  logic          amode,
  input  logic          wmode,
  input  logic          ev_clr,
  input  logic          ev_inc,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pan_addr_o,
  output logic [DW-1:0] disp_o,
  output logic [AW-1:0] acc_addr_o,
  output logic [DW-1:0] acc_wdata_o,
  output acc_kind_e     acc_o
);
  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] addr_q, sw_prev_q, acc_addr_q;
  logic [DW-1:0] disp_q, wdata_q;
  acc_kind_e     acc_q;
  logic          sw_moved;
  logic          do_inc;

  assign sw_moved = (sw_addr != sw_prev_q);
  assign do_inc   = act_ok & ~amode & ev_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      sw_prev_q  <= '0;
      acc_addr_q <= '0;
      wdata_q    <= '0;
      disp_q     <= '0;
      acc_q      <= ACC_NONE;
    end else begin
      sw_prev_q <= sw_addr;
      acc_q     <= ACC_NONE;
      if (acc_q == ACC_READ) disp_q <= mem_rdata;
      if (act_ok && amode) begin
        if (ev_clr)        addr_q <= '0;
        else if (sw_moved) addr_q <= sw_addr;
      end else if (do_inc) begin
        addr_q <= addr_next(addr_q);
        if (wmode) begin
          acc_q      <= ACC_WRITE;
          acc_addr_q <= addr_q;
          wdata_q    <= sw_data;
          disp_q     <= sw_data;
        end else begin
          acc_q      <= ACC_READ;
          acc_addr_q <= addr_next(addr_q);
        end
      end
    end
  end

  assign pan_addr_o  = addr_q;
  assign disp_o      = disp_q;
  assign acc_addr_o  = acc_addr_q;
  assign acc_wdata_o = wdata_q;
  assign acc_o       = acc_q;
endmodule

// File: rtl/fpanel_top.sv
module fpanel_top
  import fpanel_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          btn_run,
  input  logic          btn_cpu_rst,
  input  logic          btn_clear,
  input  logic          btn_incr,
  input  logic          btn_addr_mode,
  input  logic          btn_wr_mode,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_data,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_run,
  output logic          cpu_reset,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] led_addr,
  output logic [DW-1:0] led_data,
  output logic          led_run,
  output logic          led_addr_mode,
  output logic          led_wr_mode
);
  logic [NUM_BTN-1:0] btn_lvl, btn_rise, btn_q;
  logic               ev_run, ev_clr, ev_inc, ev_amode, ev_wmode;
  logic               run_st, amode_st, wmode_st, act_ok;
  logic [AW-1:0]      pan_addr, acc_addr;
  logic [DW-1:0]      disp, acc_wdata;
  acc_kind_e          acc;

  always_comb begin
    btn_lvl          = '0;
    btn_lvl[B_RUN]   = btn_run;
    btn_lvl[B_CRST]  = btn_cpu_rst;
    btn_lvl[B_CLR]   = btn_clear;
    btn_lvl[B_INC]   = btn_incr;
    btn_lvl[B_AMODE] = btn_addr_mode;
    btn_lvl[B_WMODE] = btn_wr_mode;
  end

  fpanel_edge #(.N(NUM_BTN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(btn_lvl), .rise_o(btn_rise), .lvl_q_o(btn_q)
  );

  assign ev_run   = btn_rise[B_RUN];
  assign ev_clr   = btn_rise[B_CLR];
  assign ev_inc   = btn_rise[B_INC];
  assign ev_amode = btn_rise[B_AMODE];
  assign ev_wmode = btn_rise[B_WMODE];

  fpanel_mode u_mode (
    .clk(clk), .rst_n(rst_n), .ev_run(ev_run), .ev_amode(ev_amode), .ev_wmode(ev_wmode),
    .run_o(run_st), .amode_o(amode_st), .wmode_o(wmode_st)
  );

  // panel actions only while halted and not about to start running
  assign act_ok = ~run_st & ~ev_run;

  fpanel_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .act_ok(act_ok), .amode(amode_st), .wmode(wmode_st),
    .ev_clr(ev_clr), .ev_inc(ev_inc), .sw_addr(sw_addr), .sw_data(sw_data),
    .mem_rdata(mem_rdata), .pan_addr_o(pan_addr), .disp_o(disp),
    .acc_addr_o(acc_addr), .acc_wdata_o(acc_wdata), .acc_o(acc)
  );

  assign cpu_run       = run_st;
  assign cpu_reset     = btn_q[B_CRST];
  assign mem_addr      = acc_addr;
  assign mem_wdata     = acc_wdata;
  assign mem_we        = (acc == ACC_WRITE);
  assign mem_re        = (acc == ACC_READ);
  assign led_addr      = run_st ? cpu_addr : pan_addr;
  assign led_data      = run_st ? cpu_data : disp;
  assign led_run       = run_st;
  assign led_addr_mode = amode_st;
  assign led_wr_mode   = wmode_st;
endmodule

// File: rtl/fpanel_chk.sv
module fpanel_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_run,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] led_addr,
  input logic          ev_inc,
  input logic          ev_clr,
  input logic          amode_st,
  input logic          act_ok
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R12
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> !(mem_we || mem_re));
  // R4
  strobe_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> !cpu_run);
  // R8
  write_then_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (led_addr == AW'(mem_addr + AW'(1))));
  // R9
  adv_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (led_addr == mem_addr));
  // R7
  inc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inc && amode_st) |=> !(mem_we || mem_re));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && amode_st && act_ok) |=> (led_addr == '0));
endmodule

bind fpanel_top fpanel_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_run(cpu_run), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .led_addr(led_addr), .ev_inc(ev_inc), .ev_clr(ev_clr),
  .amode_st(amode_st), .act_ok(act_ok)
);

// File: tb/sim_fpanel_top.sv
`timescale 1ns/1ps
module sim_fpanel_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_run = 0, btn_cpu_rst = 0, btn_clear = 0, btn_incr = 0;
  logic btn_addr_mode = 0, btn_wr_mode = 0;
  logic [15:0] sw_addr = '0, cpu_addr = '0;
  logic [7:0]  sw_data = '0, cpu_data = '0, mem_rdata;
  logic cpu_run, cpu_reset, mem_we, mem_re, led_run, led_addr_mode, led_wr_mode;
  logic [15:0] mem_addr, led_addr;
  logic [7:0]  mem_wdata, led_data;

  typedef struct { bit we; logic [15:0] a; logic [7:0] d; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_strobe = 0;
  logic [15:0] exp_addr;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  fpanel_top u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one press: high for one cycle, then released for two
  task automatic press(ref logic b);
    b = 1'b1; cyc(1); b = 1'b0; cyc(2);
  endtask

  task automatic push(input bit we, input logic [15:0] a, input logic [7:0] d);
    item_t it; it.we = we; it.a = a; it.d = d;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re)) begin
      item_t it;
      n_strobe++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R7/R11 unexpected access", {15'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
      end else begin
        it = exp_q.pop_front();
        chk(mem_we == it.we, "R8/R9 access kind", mem_we, it.we);
        chk(mem_addr == it.a, "R8/R9/R10 access address", mem_addr, it.a);
        if (it.we) chk(mem_wdata == it.d, "R8 write data", mem_wdata, it.d);
      end
    end
  end

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s0;
    cyc(3); rst_n = 1'b1; cyc(1);
    // R1 reset state
    chk(cpu_run == 0 && led_run == 0, "R1 run state", cpu_run, 0);
    chk(led_addr_mode == 0 && led_wr_mode == 0, "R1 modes", {led_addr_mode, led_wr_mode}, 0);
    chk(led_addr == 16'h0000 && !mem_we && !mem_re && !cpu_reset, "R1 address/strobes", led_addr, 0);

    // R3 reset button level
    btn_cpu_rst = 1; cyc(1);
    chk(cpu_reset == 1, "R3 reset asserted", cpu_reset, 1);
    btn_cpu_rst = 0; cyc(1);
    chk(cpu_reset == 0, "R3 reset released", cpu_reset, 0);

    // R5 address entry
    press(btn_addr_mode);
    chk(led_addr_mode == 1, "R5 mode on", led_addr_mode, 1);
    sw_addr = 16'h1200; cyc(2);
    chk(led_addr == 16'h1200, "R5 switch load", led_addr, 16'h1200);
    sw_addr = 16'h2040; cyc(2);
    chk(led_addr == 16'h2040, "R5 switch reload", led_addr, 16'h2040);

    // R7 increment ignored in address-entry mode
    s0 = n_strobe;
    press(btn_incr);
    chk(led_addr == 16'h2040 && n_strobe == s0, "R7 inc ignored", led_addr, 16'h2040);

    // R6 clear
    press(btn_clear);
    chk(led_addr == 16'h0000, "R6 clear in mode", led_addr, 0);
    sw_addr = 16'h0100; cyc(2);
    press(btn_addr_mode);
    chk(led_addr_mode == 0, "R5 mode off", led_addr_mode, 0);
    press(btn_clear);
    chk(led_addr == 16'h0100, "R6 clear ignored outside mode", led_addr, 16'h0100);

    // R8 deposit
    press(btn_wr_mode);
    chk(led_wr_mode == 1, "R8 deposit mode on", led_wr_mode, 1);
    exp_addr = 16'h0100;
    sw_data = 8'h3C; push(1, exp_addr, 8'h3C); press(btn_incr); exp_addr++;
    chk(led_addr == exp_addr && led_data == 8'h3C, "R8 write then advance", led_addr, exp_addr);
    sw_data = 8'hC3; push(1, exp_addr, 8'hC3); press(btn_incr); exp_addr++;
    chk(led_addr == exp_addr && led_data == 8'hC3, "R8 second write", led_addr, exp_addr);

    // R9 examine
    press(btn_wr_mode);
    exp_addr++; push(0, exp_addr, 0); press(btn_incr);
    chk(led_addr == exp_addr, "R9 address advanced", led_addr, exp_addr);
    chk(led_data == mem_model(exp_addr), "R9 read data shown", led_data, mem_model(exp_addr));

    // R10 wrap on read
    press(btn_addr_mode); sw_addr = 16'hFFFF; cyc(2); press(btn_addr_mode);
    push(0, 16'h0000, 0); press(btn_incr);
    chk(led_addr == 16'h0000 && led_data == mem_model(16'h0000), "R10 read wrap", led_addr, 0);

    // R10 wrap on write
    press(btn_addr_mode); sw_addr = 16'hFFFE; cyc(2); sw_addr = 16'hFFFF; cyc(2);
    press(btn_addr_mode); press(btn_wr_mode);
    sw_data = 8'h81; push(1, 16'hFFFF, 8'h81); press(btn_incr);
    chk(led_addr == 16'h0000 && led_data == 8'h81, "R10 write wrap", led_addr, 0);
    press(btn_wr_mode);

    // R11 held button gives one access
    s0 = n_strobe;
    push(0, 16'h0001, 0);
    btn_incr = 1; cyc(8); btn_incr = 0; cyc(3);
    chk(n_strobe == s0 + 1, "R11 one action per press", n_strobe - s0, 1);
    chk(led_addr == 16'h0001, "R11 address advanced once", led_addr, 1);

    // R2 and R4 run mode
    press(btn_run);
    chk(cpu_run == 1 && led_run == 1, "R2 run on", cpu_run, 1);
    cpu_addr = 16'hBEEF; cpu_data = 8'h77; cyc(1);
    chk(led_addr == 16'hBEEF && led_data == 8'h77, "R4 live buses shown", led_addr, 16'hBEEF);
    s0 = n_strobe;
    press(btn_incr);
    chk(n_strobe == s0, "R4 no access while running", n_strobe - s0, 0);
    press(btn_run);
    chk(cpu_run == 0 && led_run == 0, "R2 run off", cpu_run, 0);
    chk(led_addr == 16'h0001, "R4 panel address kept", led_addr, 1);

    chk(exp_q.size() == 0, "R8/R9 all expected accesses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule